// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Register Interface

This block collects up to 32 interrupt request lines and tells the processor which one to serve next. Each line has an enable bit, a pending bit and a two-bit priority. Software changes enables and pending bits through paired set and clear registers that act only on the bit positions written as one, so lines can be changed one at a time without a read-modify-write. Priorities sit in byte-wide lanes, four lines to a 32-bit word, with only the two most significant bits of each lane stored.

A request line that is high on a clock edge marks its line pending, whether or not the line is enabled. Among the lines that are both enabled and pending, the one with the numerically smallest priority wins, and the lowest line number breaks ties. The winner is presented as a valid flag, a line number and its priority. When the processor takes the interrupt it pulses the acknowledge input with the line number, and that line's pending bit is cleared.

The register port is a simple single-cycle slave: a write takes effect at the clock edge it is presented on, and read data is driven combinationally while a read is selected. Byte offsets within the block are fixed: set-enable at 0x000, clear-enable at 0x080, set-pending at 0x100, clear-pending at 0x180 and the priority words from 0x300 to 0x31C.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Synchronous reset clears every enable bit, pending bit and priority; after reset req_valid is 0 and req_line and req_prio are 0.
- R2: A write to offset 0x000 sets enable bit n for every data bit n written as 1 and leaves lines written as 0 unchanged; a read of 0x000 returns the enable vector, line n in bit n.
- R3: A write to offset 0x080 clears enable bit n for every data bit n written as 1 and leaves lines written as 0 unchanged; a read of 0x080 returns the same enable vector as 0x000.
- R4: A write to offset 0x100 marks line n pending for each data bit n written as 1, a write to 0x180 clears pending for each bit written as 1, zero bits change nothing, and reads of either offset return the pending vector.
- R5: Only the word-aligned offsets 0x000, 0x080, 0x100, 0x180 and 0x300 to 0x31C are decoded; any other offset, including one with address bits [1:0] not zero, reads as 0 and ignores writes. bus_rdata is 0 whenever no read is selected.
- R6: The priority of line n is held in the word at 0x300 + 4*(n>>2), in bits [8*(n&3)+7 : 8*(n&3)+6]; all other bits of a priority word read as 0 and ignore writes.
- R7: When irq_in[n] is high at a rising clock edge, line n is pending from the following cycle, independent of its enable bit.
- R8: When ack_valid is high at a rising clock edge, the pending bit of the line given by ack_line is cleared at that edge.
- R9: If a set source (irq_in or a set-pending write) and a clear source (acknowledge or a clear-pending write) hit the same line at the same edge, the line ends up pending.
- R10: req_valid is 1 exactly when at least one line is both enabled and pending; req_line is then the line with the numerically lowest priority, the lowest line number winning among equal priorities.
- R11: req_prio carries the winning line's two-bit priority; when req_valid is 0, req_line and req_prio are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access selected this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq_in | input | 32 | Request lines, one per interrupt |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 5 | Line whose pending bit is acknowledged |
| req_valid | output | 1 | A line is enabled and pending |
| req_line | output | 5 | Winning line number |
| req_prio | output | 2 | Priority of the winning line |

## Verification
Register writes, request lines and acknowledges all take effect at the rising edge they are presented on, so their result is due one edge later; read data and the winner outputs follow the stored state combinationally and need no further edge. The bench therefore drives every stimulus just after a falling edge, holds it across exactly one rising edge, and samples read data and the request outputs one nanosecond after the next falling edge, when the stored state has settled. Expected enables, pendings, priorities and winners come from a bench-side model updated per requirement, and the arbitration sweep repeats that over many pseudo-random enable, pending and priority patterns, including full ties and the empty case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 32;
    localparam int LANE_W    = 8;
    localparam int LANES     = DATA_W / LANE_W;
    localparam int MAX_LINES = 32;
    localparam int MAX_WORDS = MAX_LINES / LANES;
    localparam int WORD_IX_W = $clog2(MAX_WORDS);

    // Byte offsets; fixed because software depends on them.
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 10'h080;
    localparam logic [ADDR_W-1:0] OFS_PD_SET = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_PD_CLR = 10'h180;
    localparam logic [ADDR_W-1:0] OFS_PRIO   = 10'h300;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_PRIO
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [WORD_IX_W-1:0]   word;
    } reg_hit_t;

    // Map a byte offset to the register it selects.
    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.sel  = RG_NONE;
        h.word = a[WORD_IX_W+1:2];
        if (a[1:0] == 2'b00) begin
            if (a == OFS_EN_SET)      h.sel = RG_EN_SET;
            else if (a == OFS_EN_CLR) h.sel = RG_EN_CLR;
            else if (a == OFS_PD_SET) h.sel = RG_PD_SET;
            else if (a == OFS_PD_CLR) h.sel = RG_PD_CLR;
            else if (a[ADDR_W-1:WORD_IX_W+2] == OFS_PRIO[ADDR_W-1:WORD_IX_W+2])
                h.sel = RG_PRIO;
        end
        return h;
    endfunction

    // Bits of a byte lane that hold priority state.
    function automatic logic [LANE_W-1:0] lane_keep(input int prio_bits);
        logic [LANE_W-1:0] m;
        m = '0;
        for (int b = 0; b < LANE_W; b++)
            if (b >= LANE_W - prio_bits) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               bus_sel,
    input  logic                               bus_wr,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    input  logic [NUM_LINES-1:0]               pend,
    output logic [DATA_W-1:0]                  bus_rdata,
    output logic [NUM_LINES-1:0]               en,
    output logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio,
    output logic [NUM_LINES-1:0]               sw_set,
    output logic [NUM_LINES-1:0]               sw_clr
);

    reg_hit_t hit;
    logic     wr_hit;
    logic     rd_hit;
    logic [NUM_LINES-1:0] en_q;
    logic [LANE_W-1:0]    lane_img [MAX_LINES];
    logic [DATA_W-1:0]    word_img [MAX_WORDS];

    assign hit    = decode_addr(bus_addr);
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    // Enable vector: write-one-to-set and write-one-to-clear views.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_hit && hit.sel == RG_EN_SET) begin
            en_q <= en_q | bus_wdata[NUM_LINES-1:0];
        end else if (wr_hit && hit.sel == RG_EN_CLR) begin
            en_q <= en_q & ~bus_wdata[NUM_LINES-1:0];
        end
    end
    assign en = en_q;

    // Pending requests from software go to the pending cells.
    assign sw_set = (wr_hit && hit.sel == RG_PD_SET) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign sw_clr = (wr_hit && hit.sel == RG_PD_CLR) ? bus_wdata[NUM_LINES-1:0] : '0;

    // One priority field per line, stored in the top bits of its lane.
    for (genvar i = 0; i < MAX_LINES; i++) begin : g_prio
        localparam int WORD = i / LANES;
        localparam int LANE = i % LANES;
        if (i < NUM_LINES) begin : g_live
            logic [PRIO_BITS-1:0] lvl_q;
            logic                 wr_me;
            assign wr_me = wr_hit && hit.sel == RG_PRIO
                        && hit.word == WORD_IX_W'(WORD);
            always_ff @(posedge clk) begin
                if (rst)
                    lvl_q <= '0;
                else if (wr_me)
                    lvl_q <= bus_wdata[LANE*LANE_W + LANE_W-1 -: PRIO_BITS];
            end
            assign prio[i]     = lvl_q;
            if (PRIO_BITS < LANE_W) begin : g_pad
                assign lane_img[i] = {lvl_q, {(LANE_W-PRIO_BITS){1'b0}}};
            end else begin : g_full
                assign lane_img[i] = lvl_q;
            end
        end else begin : g_absent
            assign lane_img[i] = '0;
        end
    end

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign word_img[w][l*LANE_W +: LANE_W] = lane_img[w*LANES + l];
        end
    end

    // Read data, zero outside a read.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (hit.sel)
                RG_EN_SET, RG_EN_CLR: bus_rdata[NUM_LINES-1:0] = en_q;
                RG_PD_SET, RG_PD_CLR: bus_rdata[NUM_LINES-1:0] = pend;
                RG_PRIO:              bus_rdata = word_img[hit.word];
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    output logic [NUM_LINES-1:0] pend
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cell
        logic pend_q;
        logic set_any;
        logic clr_any;

        assign set_any = irq_in[i] | sw_set[i];
        assign clr_any = sw_clr[i] | (ack_valid && ack_line == LINE_W'(i));

        // A set at the same edge as a clear keeps the request.
        always_ff @(posedge clk) begin
            if (rst)
                pend_q <= 1'b0;
            else if (set_any)
                pend_q <= 1'b1;
            else if (clr_any)
                pend_q <= 1'b0;
        end

        assign pend[i] = pend_q;
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2,
    parameter int LINE_W    = 5
) (
    input  logic [NUM_LINES-1:0]                en,
    input  logic [NUM_LINES-1:0]                pend,
    input  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio,
    output logic                                req_valid,
    output logic [LINE_W-1:0]                   req_line,
    output logic [PRIO_BITS-1:0]                req_prio
);

    localparam int LEAVES = 1 << LINE_W;
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int KEY_W  = PRIO_BITS + LINE_W;

    // Key = {priority, line}: the smaller key wins, so equal
    // priorities fall back to the lower line number.
    logic [LEAVES-1:0] leaf_v;
    logic [KEY_W-1:0]  leaf_k [LEAVES];
    logic              node_v [NODES];
    logic [KEY_W-1:0]  node_k [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_LINES) begin : g_real
            assign leaf_v[i] = en[i] & pend[i];
            assign leaf_k[i] = {prio[i], LINE_W'(i)};
        end else begin : g_pad
            assign leaf_v[i] = 1'b0;
            assign leaf_k[i] = {{PRIO_BITS{1'b0}}, LINE_W'(i)};
        end
    end

    // Heap-ordered comparison tree, children of j at 2j+1 and 2j+2.
    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            node_v[LEAVES-1+i] = leaf_v[i];
            node_k[LEAVES-1+i] = leaf_k[i];
        end
        for (int j = LEAVES - 2; j >= 0; j--) begin
            logic take_left;
            take_left = node_v[2*j+1]
                     && (!node_v[2*j+2] || node_k[2*j+1] <= node_k[2*j+2]);
            node_v[j] = node_v[2*j+1] | node_v[2*j+2];
            node_k[j] = take_left ? node_k[2*j+1] : node_k[2*j+2];
        end
    end

    assign req_valid = node_v[0];
    assign req_line  = node_v[0] ? node_k[0][LINE_W-1:0]     : '0;
    assign req_prio  = node_v[0] ? node_k[0][KEY_W-1:LINE_W] : '0;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [irqc_pkg::ADDR_W-1:0]      bus_addr,
    input  logic [irqc_pkg::DATA_W-1:0]      bus_wdata,
    output logic [irqc_pkg::DATA_W-1:0]      bus_rdata,
    input  logic [NUM_LINES-1:0]             irq_in,
    input  logic                             ack_valid,
    input  logic [LINE_W-1:0]                ack_line,
    output logic                             req_valid,
    output logic [LINE_W-1:0]                req_line,
    output logic [PRIO_BITS-1:0]             req_prio
);

    logic [NUM_LINES-1:0]                en_q;
    logic [NUM_LINES-1:0]                pend_q;
    logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio_q;
    logic [NUM_LINES-1:0]                sw_set;
    logic [NUM_LINES-1:0]                sw_clr;

    irqc_regs #(
        .NUM_LINES (NUM_LINES),
        .PRIO_BITS (PRIO_BITS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (pend_q),
        .bus_rdata (bus_rdata),
        .en        (en_q),
        .prio      (prio_q),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr)
    );

    irqc_pend #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .pend      (pend_q)
    );

    irqc_arb #(
        .NUM_LINES (NUM_LINES),
        .PRIO_BITS (PRIO_BITS),
        .LINE_W    (LINE_W)
    ) u_arb (
        .en        (en_q),
        .pend      (pend_q),
        .prio      (prio_q),
        .req_valid (req_valid),
        .req_line  (req_line),
        .req_prio  (req_prio)
    );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [irqc_pkg::ADDR_W-1:0] bus_addr,
    input logic [irqc_pkg::DATA_W-1:0] bus_wdata,
    input logic [irqc_pkg::DATA_W-1:0] bus_rdata,
    input logic [NUM_LINES-1:0]        irq_in,
    input logic                        ack_valid,
    input logic [LINE_W-1:0]           ack_line,
    input logic                        req_valid,
    input logic [LINE_W-1:0]           req_line,
    input logic [NUM_LINES-1:0]        en,
    input logic [NUM_LINES-1:0]        pend
);

    localparam logic [7:0]  KEEP_LANE = irqc_pkg::lane_keep(PRIO_BITS);
    localparam logic [31:0] KEEP_WORD = {4{KEEP_LANE}};

    logic [NUM_LINES-1:0] wd;
    logic                 was_rst = 1'b0;

    assign wd = bus_wdata[NUM_LINES-1:0];

    // R1: the cycle after reset everything is clear
    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (was_rst && !rst) begin
            p_reset_clear_r1: assert (en == '0 && pend == '0 && !req_valid)
                else $error("R1 state not cleared by reset");
        end
    end

    // R2
    p_enable_set_r2: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && bus_addr == 10'h000
        |=> (en & $past(wd)) == $past(wd));

    // R3
    p_enable_clear_r3: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && bus_addr == 10'h080
        |=> (en & $past(wd)) == '0);

    // R5: the gap between pending and priority registers reads zero
    p_gap_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_wr && bus_addr[9:8] == 2'b10 |-> bus_rdata == '0);

    // R6
    p_prio_lane_bits_r6: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_wr && bus_addr[9:5] == 5'b11000
        |-> (bus_rdata & ~KEEP_WORD) == '0);

    // R7
    p_irq_sets_pending_r7: assert property (@(posedge clk) disable iff (rst)
        |irq_in |=> (pend & $past(irq_in)) == $past(irq_in));

    // R8
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !irq_in[ack_line]
        && !(bus_sel && bus_wr && bus_addr == 10'h100 && bus_wdata[ack_line])
        |=> !pend[$past(ack_line)]);

    // R9
    p_set_beats_ack_r9: assert property (@(posedge clk) disable iff (rst)
        ack_valid && irq_in[ack_line] |=> pend[$past(ack_line)]);

    // R10
    p_valid_matches_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid == |(en & pend));

    p_winner_live_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> en[req_line] && pend[req_line]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .ack_valid (ack_valid),
    .ack_line  (ack_line),
    .req_valid (req_valid),
    .req_line  (req_line),
    .en        (en_q),
    .pend      (pend_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    localparam logic [9:0] A_ENS = 10'h000;
    localparam logic [9:0] A_ENC = 10'h080;
    localparam logic [9:0] A_PDS = 10'h100;
    localparam logic [9:0] A_PDC = 10'h180;
    localparam logic [9:0] A_PRI = 10'h300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_line = '0;
    logic        req_valid;
    logic [4:0]  req_line;
    logic [1:0]  req_prio;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_en;
    logic [31:0] m_pend;
    logic [1:0]  m_prio [32];
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .req_valid (req_valid),
        .req_line  (req_line),
        .req_prio  (req_prio)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [9:0] a, logic [31:0] d);
        if (a == A_ENS) m_en = m_en | d;
        else if (a == A_ENC) m_en = m_en & ~d;
        else if (a == A_PDS) m_pend = m_pend | d;
        else if (a == A_PDC) m_pend = m_pend & ~d;
        else if (a >= A_PRI && a <= 10'h31C && a[1:0] == 2'b00) begin
            int w;
            w = int'(a - A_PRI) / 4;
            for (int l = 0; l < 4; l++) m_prio[w*4+l] = d[l*8+6 +: 2];
        end
    endtask

    task automatic bus_write(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] prio_word(int w);
        logic [31:0] v;
        v = '0;
        for (int l = 0; l < 4; l++) v[l*8+6 +: 2] = m_prio[w*4+l];
        return v;
    endfunction

    task automatic check_regs(string tag);
        logic [31:0] d;
        bus_read(A_ENS, d); check({tag, " R2 enable@000"}, d, m_en);
        bus_read(A_ENC, d); check({tag, " R3 enable@080"}, d, m_en);
        bus_read(A_PDS, d); check({tag, " R4 pending@100"}, d, m_pend);
        bus_read(A_PDC, d); check({tag, " R4 pending@180"}, d, m_pend);
    endtask

    task automatic check_req(string tag);
        int best;
        best = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pend[i] && (best < 0 || m_prio[i] < m_prio[best]))
                best = i;
        #1;
        check({tag, " R10 valid"}, {31'b0, req_valid}, {31'b0, best >= 0});
        check({tag, " R10 line"}, {27'b0, req_line}, best >= 0 ? 32'(best) : 32'd0);
        check({tag, " R11 prio"}, {30'b0, req_prio},
              best >= 0 ? {30'b0, m_prio[best]} : 32'd0);
    endtask

    function automatic int winner();
        int best;
        best = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pend[i] && (best < 0 || m_prio[i] < m_prio[best]))
                best = i;
        return best;
    endfunction

    task automatic step_lcg();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
    endtask

    initial begin
        logic [31:0] d;
        m_en = '0; m_pend = '0;
        for (int i = 0; i < 32; i++) m_prio[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything clear after reset
        check_regs("R1 reset");
        for (int w = 0; w < 8; w++) begin
            bus_read(10'(A_PRI + 4*w), d);
            check("R1 reset priority word", d, 32'h0);
        end
        check_req("R1 reset");

        // R2 / R3: one line at a time, then zero-bit writes
        for (int n = 0; n < 32; n++) begin
            bus_write(A_ENS, 32'h1 << n);
            bus_read(A_ENS, d); check("R2 set-enable walk", d, m_en);
        end
        bus_write(A_ENS, 32'h0);
        bus_read(A_ENS, d); check("R2 zero write keeps enables", d, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n += 2) begin
            bus_write(A_ENC, 32'h1 << n);
            bus_read(A_ENC, d); check("R3 clear-enable walk", d, m_en);
        end
        bus_write(A_ENC, 32'h0);
        bus_read(A_ENC, d); check("R3 zero write keeps enables", d, 32'hAAAA_AAAA);

        // R6: priority lanes
        for (int w = 0; w < 8; w++) begin
            bus_write(10'(A_PRI + 4*w), 32'hFFFF_FFFF);
            bus_read(10'(A_PRI + 4*w), d);
            check("R6 all-ones keeps lane tops", d, 32'hC0C0_C0C0);
        end
        for (int w = 0; w < 8; w++) begin
            bus_write(10'(A_PRI + 4*w), 32'(w) * 32'h1357_9BDF ^ 32'h5A3C_96E1);
            bus_read(10'(A_PRI + 4*w), d);
            check("R6 priority pattern", d, prio_word(w));
        end

        // R4: pending set/clear views
        bus_write(A_PDS, 32'h8421_0F0F);
        check_regs("R4 set-pending");
        bus_write(A_PDC, 32'h0000_0F01);
        check_regs("R4 clear-pending");
        bus_write(A_PDS, 32'h0);
        bus_write(A_PDC, 32'h0);
        check_regs("R4 zero writes");

        // R5: undecoded and misaligned offsets
        begin
            logic [9:0] bad [6];
            bad[0] = 10'h004; bad[1] = 10'h040; bad[2] = 10'h200;
            bad[3] = 10'h320; bad[4] = 10'h302; bad[5] = 10'h081;
            for (int b = 0; b < 6; b++) begin
                bus_write(bad[b], 32'hFFFF_FFFF);
                bus_read(bad[b], d);
                check("R5 undecoded reads zero", d, 32'h0);
            end
            check_regs("R5 after undecoded writes");
            bus_read(A_PRI, d); check("R5 priority word 0 untouched", d, prio_word(0));
            #1;
            check("R5 rdata idle", bus_rdata, 32'h0);
        end

        // R7: request line sets pending while the line is disabled
        bus_write(A_ENC, 32'hFFFF_FFFF);
        bus_write(A_PDC, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'h0000_0020;
        @(negedge clk); irq_in = '0; m_pend[5] = 1'b1;
        #1;
        check("R7 pending after one edge, no request", {31'b0, req_valid}, 32'h0);
        bus_read(A_PDS, d); check("R7 irq latched while disabled", d, 32'h0000_0020);
        bus_write(A_ENS, 32'h0000_0020);
        check_req("R7 enabled later");

        // R10 / R11: arbitration sweep
        for (int k = 0; k < 48; k++) begin
            bus_write(A_ENC, 32'hFFFF_FFFF);
            bus_write(A_PDC, 32'hFFFF_FFFF);
            for (int w = 0; w < 8; w++) begin
                step_lcg();
                bus_write(10'(A_PRI + 4*w), (k % 4 == 0) ? 32'h0 : lcg);
            end
            step_lcg();
            if (k == 1) begin
                bus_write(A_ENS, 32'h8000_0000);
                bus_write(A_PDS, 32'h8000_0000);
            end else if (k == 2) begin
                bus_write(A_ENS, 32'h0F0F_0F0F);
                bus_write(A_PDS, 32'hF0F0_F0F0);
            end else begin
                bus_write(A_ENS, lcg);
                step_lcg();
                bus_write(A_PDS, lcg ^ 32'h00FF_0000);
            end
            check_req("R10 sweep");
        end

        // R8: acknowledge the winner until nothing is left
        bus_write(A_ENS, 32'hFFFF_FFFF);
        bus_write(A_PDS, 32'h9C03_6A51);
        for (int it = 0; it < 33; it++) begin
            int w;
            w = winner();
            if (w < 0) break;
            @(negedge clk); ack_valid = 1'b1; ack_line = 5'(w);
            @(negedge clk); ack_valid = 1'b0; m_pend[w] = 1'b0;
            bus_read(A_PDS, d); check("R8 ack clears pending", d, m_pend);
            check_req("R8 next winner");
        end

        // R9: set and clear on the same line at the same edge
        @(negedge clk); irq_in = 32'h0000_1000; ack_valid = 1'b1; ack_line = 5'd12;
        @(negedge clk); irq_in = '0; ack_valid = 1'b0; m_pend[12] = 1'b1;
        bus_read(A_PDS, d); check("R9 irq beats ack", d, m_pend);

        @(negedge clk);
        irq_in = 32'h0040_0000;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PDC; bus_wdata = 32'h0040_1000;
        @(negedge clk);
        irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        m_pend[12] = 1'b0; m_pend[22] = 1'b1;
        bus_read(A_PDS, d); check("R9 irq beats clear-pending write", d, m_pend);

        @(negedge clk);
        ack_valid = 1'b1; ack_line = 5'd3;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PDS; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        ack_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; m_pend[3] = 1'b1;
        bus_read(A_PDS, d); check("R9 set-pending write beats ack", d, m_pend);
        check_req("R9 final");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule